// File: doc/BRIEF.md
# Bitplane fetch window sequencer

This block decides, bus cycle by bus cycle, whether a raster video chip spends a memory slot on bitplane data, and for which plane. Software programs a fetch-start position, a fetch-stop position and an active plane count through a small write port. The block compares start and stop against a horizontal counter that runs four cycles ahead of the visible position. Each match then passes through a four-stage delay before it opens or closes the fetch window. While the window is open, slots repeat in groups of eight, and each slot belongs to one plane in a fixed order.

Plane-count changes pass through the same four-stage delay, so a mid-line write alters the fetch pattern exactly four cycles later. A master DMA enable masks requests in the same cycle but does not stall the window or slot tracking. Memory arbitration, pointers, pixel shifting and vertical limits belong to neighbouring blocks.

Top module: `bpl_fetch_seq`

## Requirements
- R1: While rst_ni is low and after its release, fetch_o and plane_o are 0. Start, stop and plane count reset to 0, so no fetch is issued until the plane count is written.
- R2: A start match occurs in the cycle where (hpos_i + 4) modulo LINE_LEN equals the start value. The window then opens in the cycle where hpos_i equals the start value, and no fetch is issued before that.
- R3: A stop match is detected the same way. The window is closed from the cycle where hpos_i equals the stop value. If start and stop match in the same cycle, the window stays closed.
- R4: If no stop match closes it, the window closes after the cycle with hpos_i = LINE_LEN-1, unless a start match that is due in that cycle opens it again.
- R5: A start or stop compare uses the value written to that register in the same cycle, if there is one; otherwise it uses the stored value. A write one cycle after the matching count misses it.
- R6: The window phase is the number of cycles since it opened, modulo 8. Phases 0 and 4 are idle. Phases 1, 2, 3, 5, 6 and 7 carry planes 3, 5, 1, 2, 4 and 0.
- R7: A plane is fetched only if its index is below the active plane count. The count is taken from wr_data_i[2:0], and values above 6 act as 6. A new count governs fetches from exactly four cycles after its write cycle.
- R8: fetch_o is 0 in any cycle where dma_en_i is 0. The window and its phase keep advancing meanwhile.
- R9: plane_o is 0 in any cycle where fetch_o is 0.
- R10: When wr_en_i is high, wr_addr_i selects the register written: 0 is start, 1 is stop, 2 is plane count. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus cycle clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| hpos_i | input | POS_W | visible horizontal position |
| line_start_i | input | 1 | high in the cycle where hpos_i is 0 |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 2 | register select |
| wr_data_i | input | POS_W | write data |
| dma_en_i | input | 1 | master bitplane DMA enable |
| fetch_o | output | 1 | fetch request for this cycle |
| plane_o | output | 3 | plane index of the request |

## Verification
A match is taken combinationally in its own cycle, four cycles before hpos_i reaches the programmed value. The window register changes at the fourth edge after the match, so the window opens or closes in the cycle whose hpos_i equals the register value. A plane-count write governs fetches four edges after it is sampled, and dma_en_i acts in the same cycle. The bench drives each cycle's inputs just after the falling edge and reads fetch_o and plane_o one time unit later. It compares them against a cycle model that holds four cycles of match and count history, and checks the per-line counts and first-fetch positions against hand-computed values.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  localparam int BFS_DELAY   = 4;
  localparam int GROUP_SLOTS = 8;
  localparam int PLANE_IDX_W = 3;

  typedef enum logic [1:0] {
    REG_START  = 2'd0,
    REG_STOP   = 2'd1,
    REG_PLANES = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic start_hit;
    logic stop_hit;
  } win_evt_t;

  typedef struct packed {
    logic                   valid;
    logic [PLANE_IDX_W-1:0] plane;
  } slot_t;

  // fixed plane order inside one eight-slot group
  function automatic slot_t slot_map(input logic [2:0] ph);
    slot_t s;
    s = '0;
    unique case (ph)
      3'd1: s = '{valid: 1'b1, plane: 3'd3};
      3'd2: s = '{valid: 1'b1, plane: 3'd5};
      3'd3: s = '{valid: 1'b1, plane: 3'd1};
      3'd5: s = '{valid: 1'b1, plane: 3'd2};
      3'd6: s = '{valid: 1'b1, plane: 3'd4};
      3'd7: s = '{valid: 1'b1, plane: 3'd0};
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bfs_regs.sv
module bfs_regs
  import bfs_pkg::*;
#(
  parameter int POS_W      = 9,
  parameter int PLANE_W    = 3,
  parameter int MAX_PLANES = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [POS_W-1:0]   wr_data_i,
  output logic [POS_W-1:0]   start_eff_o,
  output logic [POS_W-1:0]   stop_eff_o,
  output logic [PLANE_W-1:0] planes_eff_o
);

  localparam logic [PLANE_W-1:0] PL_MAX = PLANE_W'(MAX_PLANES);

  logic [POS_W-1:0]   start_q, stop_q;
  logic [PLANE_W-1:0] planes_q;
  logic [PLANE_W-1:0] planes_wr;
  logic               wr_start, wr_stop, wr_planes;

  assign wr_start  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_START);
  assign wr_stop   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_STOP);
  assign wr_planes = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_PLANES);

  always_comb begin
    planes_wr = wr_data_i[PLANE_W-1:0];
    if (planes_wr > PL_MAX) planes_wr = PL_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      stop_q   <= '0;
      planes_q <= '0;
    end else begin
      if (wr_start)  start_q  <= wr_data_i;
      if (wr_stop)   stop_q   <= wr_data_i;
      if (wr_planes) planes_q <= planes_wr;
    end
  end

  // same-cycle writes are seen by this cycle's compare
  assign start_eff_o  = wr_start  ? wr_data_i : start_q;
  assign stop_eff_o   = wr_stop   ? wr_data_i : stop_q;
  assign planes_eff_o = wr_planes ? planes_wr : planes_q;

endmodule

// File: rtl/bfs_lookahead.sv
module bfs_lookahead #(
  parameter int POS_W     = 9,
  parameter int LINE_LEN  = 228,
  parameter int LOOKAHEAD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] stop_i,
  output logic [POS_W-1:0] la_o,
  output logic             start_hit_o,
  output logic             stop_hit_o
);

  localparam logic [POS_W-1:0] LA_INIT = POS_W'(LOOKAHEAD);
  localparam logic [POS_W-1:0] LA_LAST = POS_W'(LINE_LEN - 1);

  logic [POS_W-1:0] la_q, la_now;

  assign la_now = line_start_i ? LA_INIT : la_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                la_q <= LA_INIT;
    else if (la_now == LA_LAST) la_q <= '0;
    else                        la_q <= la_now + 1'b1;
  end

  assign la_o        = la_now;
  assign start_hit_o = (la_now == start_i);
  assign stop_hit_o  = (la_now == stop_i);

endmodule

// File: rtl/bfs_delay_pipe.sv
module bfs_delay_pipe #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/bfs_slot_gen.sv
module bfs_slot_gen
  import bfs_pkg::*;
#(
  parameter int POS_W    = 9,
  parameter int LINE_LEN = 228,
  parameter int PLANE_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [POS_W-1:0]       hpos_i,
  input  win_evt_t               evt_i,
  input  logic [PLANE_W-1:0]     planes_i,
  input  logic                   dma_en_i,
  output logic                   win_o,
  output logic                   fetch_o,
  output logic [PLANE_IDX_W-1:0] plane_o
);

  localparam int PH_W = $clog2(GROUP_SLOTS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_LEN - 1);

  logic            win_q, win_d;
  logic [PH_W-1:0] phase_q, phase_d;
  slot_t           slot;
  logic            plane_ok;

  // stop beats start; a due start beats line end
  always_comb begin
    if (evt_i.stop_hit)         win_d = 1'b0;
    else if (evt_i.start_hit)   win_d = 1'b1;
    else if (hpos_i == POS_LAST) win_d = 1'b0;
    else                        win_d = win_q;
  end

  always_comb begin
    if (!win_d)     phase_d = '0;
    else if (win_q) phase_d = phase_q + 1'b1;
    else            phase_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      win_q   <= win_d;
      phase_q <= phase_d;
    end
  end

  assign slot     = slot_map(3'(phase_q));
  assign plane_ok = (PLANE_W'(slot.plane) < planes_i);
  assign fetch_o  = win_q && dma_en_i && slot.valid && plane_ok;
  assign plane_o  = fetch_o ? slot.plane : '0;
  assign win_o    = win_q;

endmodule

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq
  import bfs_pkg::*;
#(
  parameter int POS_W      = 9,
  parameter int LINE_LEN   = 228,
  parameter int MAX_PLANES = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [POS_W-1:0]       hpos_i,
  input  logic                   line_start_i,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_addr_i,
  input  logic [POS_W-1:0]       wr_data_i,
  input  logic                   dma_en_i,
  output logic                   fetch_o,
  output logic [PLANE_IDX_W-1:0] plane_o
);

  localparam int PLANE_W  = PLANE_IDX_W;
  localparam int EVT_W    = $bits(win_evt_t);
  localparam int EVT_DEPTH = BFS_DELAY - 1; // window register is the last stage

  logic [POS_W-1:0]   start_eff, stop_eff, la_w;
  logic [PLANE_W-1:0] planes_eff, planes_act;
  logic               start_hit, stop_hit, win_w;
  win_evt_t           evt_now, evt_dly;

  bfs_regs #(.POS_W(POS_W), .PLANE_W(PLANE_W), .MAX_PLANES(MAX_PLANES)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .start_eff_o (start_eff),
    .stop_eff_o  (stop_eff),
    .planes_eff_o(planes_eff)
  );

  bfs_lookahead #(.POS_W(POS_W), .LINE_LEN(LINE_LEN), .LOOKAHEAD(BFS_DELAY)) u_la (
    .clk_i, .rst_ni, .line_start_i,
    .start_i    (start_eff),
    .stop_i     (stop_eff),
    .la_o       (la_w),
    .start_hit_o(start_hit),
    .stop_hit_o (stop_hit)
  );

  assign evt_now = '{start_hit: start_hit, stop_hit: stop_hit};

  bfs_delay_pipe #(.WIDTH(EVT_W), .DEPTH(EVT_DEPTH)) u_evt_pipe (
    .clk_i, .rst_ni,
    .d_i(evt_now),
    .q_o(evt_dly)
  );

  bfs_delay_pipe #(.WIDTH(PLANE_W), .DEPTH(BFS_DELAY)) u_pl_pipe (
    .clk_i, .rst_ni,
    .d_i(planes_eff),
    .q_o(planes_act)
  );

  bfs_slot_gen #(.POS_W(POS_W), .LINE_LEN(LINE_LEN), .PLANE_W(PLANE_W)) u_slot (
    .clk_i, .rst_ni, .hpos_i,
    .evt_i   (evt_dly),
    .planes_i(planes_act),
    .dma_en_i,
    .win_o   (win_w),
    .fetch_o,
    .plane_o
  );

endmodule

// File: rtl/bpl_fetch_seq_chk.sv
module bpl_fetch_seq_chk #(
  parameter int PLANE_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dma_en_i,
  input logic               fetch_o,
  input logic [2:0]         plane_o,
  input logic               win_i,
  input logic               start_hit_i,
  input logic               stop_hit_i,
  input logic [PLANE_W-1:0] planes_eff_i,
  input logic [PLANE_W-1:0] planes_act_i
);

  logic [2:0] age_q;
  logic       aged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 1'b1;
  end
  assign aged = (age_q == 3'd4);

  AST_FETCH_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> win_i); // R2

  AST_OPEN_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && $rose(win_i)) |-> $past(start_hit_i, 4)); // R2

  AST_CLOSE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && $past(stop_hit_i, 4)) |-> !win_i); // R3

  AST_PLANES_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged |-> (planes_act_i == $past(planes_eff_i, 4))); // R7

  AST_PLANE_BELOW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> (PLANE_W'(plane_o) < planes_act_i)); // R7

  AST_FETCH_NEEDS_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> dma_en_i); // R8

  AST_IDLE_PLANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_o |-> (plane_o == 3'd0)); // R9

endmodule

bind bpl_fetch_seq bpl_fetch_seq_chk #(.PLANE_W(PLANE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dma_en_i    (dma_en_i),
  .fetch_o     (fetch_o),
  .plane_o     (plane_o),
  .win_i       (win_w),
  .start_hit_i (start_hit),
  .stop_hit_i  (stop_hit),
  .planes_eff_i(planes_eff),
  .planes_act_i(planes_act)
);

// File: tb/bpl_fetch_seq_test.sv
module bpl_fetch_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 228;
  localparam int PW = 9;
  localparam int NROWS = 10;
  localparam int NONE = 511;

  // {start, stop, planes, dma, expected count, expected first hpos}
  localparam logic [38:0] VEC [NROWS] = '{
    {9'd24,  9'd64,  3'd6, 1'b1, 8'd30,  9'd25},
    {9'd24,  9'd64,  3'd2, 1'b1, 8'd10,  9'd27},
    {9'd24,  9'd64,  3'd3, 1'b1, 8'd15,  9'd27},
    {9'd24,  9'd64,  3'd0, 1'b1, 8'd0,   9'd511},
    {9'd24,  9'd64,  3'd6, 1'b0, 8'd0,   9'd511},
    {9'd24,  9'd64,  3'd7, 1'b1, 8'd30,  9'd25},
    {9'd100, 9'd108, 3'd6, 1'b1, 8'd6,   9'd101},
    {9'd200, 9'd300, 3'd6, 1'b1, 8'd21,  9'd201},
    {9'd60,  9'd40,  3'd6, 1'b1, 8'd126, 9'd61},
    {9'd50,  9'd50,  3'd6, 1'b1, 8'd0,   9'd511}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [PW-1:0] hpos = '0;
  logic          line_start = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [PW-1:0] wr_data = '0;
  logic          dma_en = 1'b0;
  logic          fetch;
  logic [2:0]    plane;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpl_fetch_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .hpos_i(hpos), .line_start_i(line_start),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dma_en_i(dma_en), .fetch_o(fetch), .plane_o(plane)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  int m_start, m_stop, m_np, m_phase;
  bit m_win;
  bit hs_s [3];
  bit hs_t [3];
  int hn   [4];

  bit obs_f [L];
  int obs_p [L];
  int line_cnt, line_first;

  function automatic int clampp(input int v);
    return (v > 6) ? 6 : v;
  endfunction

  task automatic model_reset();
    m_start = 0; m_stop = 0; m_np = 0; m_phase = 0; m_win = 0;
    for (int i = 0; i < 3; i++) begin hs_s[i] = 0; hs_t[i] = 0; end
    for (int i = 0; i < 4; i++) hn[i] = 0;
  endtask

  // R6 slot order
  task automatic ref_slot(input int ph, output bit v, output int p);
    v = 1;
    case (ph)
      1: p = 3;  2: p = 5;  3: p = 1;
      5: p = 2;  6: p = 4;  7: p = 0;
      default: begin v = 0; p = 0; end
    endcase
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic one_cycle(input int h, input bit we, input int a, input int d, input bit dma);
    int se, te, ne, la, p, ep;
    bit sh, th, v, ef, nw;
    @(negedge clk);
    hpos = PW'(h); line_start = (h == 0);
    wr_en = we; wr_addr = 2'(a); wr_data = PW'(d); dma_en = dma;
    #1;
    se = (we && a == 0) ? d : m_start;
    te = (we && a == 1) ? d : m_stop;
    ne = (we && a == 2) ? clampp(d & 7) : m_np;
    la = (h + 4) % L;
    sh = (la == se);
    th = (la == te);
    ref_slot(m_phase, v, p);
    ef = m_win && dma && v && (p < hn[3]);
    ep = ef ? p : 0;
    n_tests++;
    if (fetch !== ef || int'(plane) != ep) begin
      n_fail++;
      $display("FAIL R6/R7/R8/R9 model hpos %0d: actual fetch %0b plane %0d expected fetch %0b plane %0d",
               h, fetch, plane, ef, ep);
    end
    obs_f[h] = fetch;
    obs_p[h] = int'(plane);
    if (fetch) begin
      line_cnt++;
      if (line_first == NONE) line_first = h;
    end
    // R2 R3 R4 window update from match three cycles back
    if (hs_t[2])         nw = 0;
    else if (hs_s[2])    nw = 1;
    else if (h == L - 1) nw = 0;
    else                 nw = m_win;
    m_phase = nw ? (m_win ? (m_phase + 1) % 8 : 0) : 0;
    m_win = nw;
    hs_s[2] = hs_s[1]; hs_s[1] = hs_s[0]; hs_s[0] = sh;
    hs_t[2] = hs_t[1]; hs_t[1] = hs_t[0]; hs_t[0] = th;
    hn[3] = hn[2]; hn[2] = hn[1]; hn[1] = hn[0]; hn[0] = ne;
    if (we) begin
      case (a)
        0: m_start = d;
        1: m_stop  = d;
        2: m_np    = clampp(d & 7);
        default: ;
      endcase
    end
  endtask

  task automatic run_line(input int st, input int sp, input int np, input bit dma_pre,
                          input int dma_h, input int mid_h, input int mid_a, input int mid_d);
    line_cnt = 0; line_first = NONE;
    for (int h = 0; h < L; h++) begin
      bit we; int a, d; bit dm;
      we = 0; a = 0; d = 0;
      if (h == 0 && st >= 0)      begin we = 1; a = 0; d = st; end
      else if (h == 1 && sp >= 0) begin we = 1; a = 1; d = sp; end
      else if (h == 2 && np >= 0) begin we = 1; a = 2; d = np; end
      else if (h == mid_h)        begin we = 1; a = mid_a; d = mid_d; end
      dm = (dma_h >= 0 && h >= dma_h) ? 1'b1 : dma_pre;
      one_cycle(h, we, a, d, dm);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 fetch in reset", int'(fetch), 0);
    check("R1 plane in reset", int'(plane), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 fetch after release", int'(fetch), 0);

    // R2 R3 R4 R6 R7 R8: table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [38:0] r;
      r = VEC[i];
      run_line(int'(r[38:30]), int'(r[29:21]), int'(r[20:18]), r[17], -1, -1, 0, 0);
      check($sformatf("R2 R3 R4 R6 R7 table row %0d count", i), line_cnt, int'(r[16:9]));
      check($sformatf("R2 R3 R6 table row %0d first hpos", i), line_first, int'(r[8:0]));
    end

    // R5 start written in the matching cycle
    run_line(300, 64, 6, 1, -1, 26, 0, 30);
    check("R5 same-cycle start count", line_cnt, 25);
    check("R5 same-cycle start first", line_first, 31);
    run_line(300, 64, 6, 1, -1, 25, 0, 30);
    check("R5 early start count", line_cnt, 25);
    run_line(300, 64, 6, 1, -1, 27, 0, 30);
    check("R5 late start count", line_cnt, 0);

    // R5 R3 stop written in the matching cycle
    run_line(24, 300, 6, 1, -1, 60, 1, 64);
    check("R5 same-cycle stop count", line_cnt, 30);
    check("R3 no fetch at stop hpos", int'(obs_f[65]), 0);

    // R7 plane count change lands four cycles later
    run_line(24, 64, 6, 1, -1, 30, 2, 0);
    check("R7 fetch before change", int'(obs_f[33]), 1);
    check("R7 no fetch after change", int'(obs_f[34]), 0);
    check("R7 shrink count", line_cnt, 7);
    run_line(24, 64, 0, 1, -1, 30, 2, 6);
    check("R7 grow first hpos", line_first, 34);
    check("R7 grow first plane", obs_p[34], 5);
    check("R7 grow count", line_cnt, 23);

    // R8 dma re-enabled mid-window keeps phase
    run_line(24, 64, 6, 0, 40, -1, 0, 0);
    check("R8 dma count", line_cnt, 18);
    check("R8 dma first hpos", line_first, 41);
    check("R8 dma first plane", obs_p[41], 3);

    // R10 address 3 ignored
    run_line(300, 64, 6, 1, -1, 26, 3, 30);
    check("R10 addr 3 ignored", line_cnt, 0);

    // R1 reset mid-run clears registers
    run_line(24, 64, 6, 1, -1, -1, 0, 0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 fetch during reset", int'(fetch), 0);
    check("R1 plane during reset", int'(plane), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    run_line(-1, -1, -1, 1, -1, -1, 0, 0);
    check("R1 no fetch after reset", line_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule